// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block sets the reset timing of a processor supervisor. It watches two sources that call for reset: a supply-good flag, already synchronised, from an external voltage comparator, and an active-low manual-reset request. While either source is active, reset is driven at once. When both have cleared, reset is held for a fixed number of timebase ticks before it is released. The timebase is a one-cycle enable pulse supplied from outside, so the same logic serves any recovery period from microseconds to hundreds of milliseconds.

Reset is presented at two polarities, active-low and active-high. A parameter selects whether both outputs are driven or only one of them. An unused output is held at its inactive level. A status output is high while the recovery count is running, which shows whether reset is being held by a cause or by the timer.

Top module: `sup_rst_gen`

## Requirements
- R1: While `supply_ok` is 0 or `mr_n` is 0, reset is asserted in the same cycle (`rst_n_out` = 0), with no register between the cause and the output.
- R2: Once both causes have cleared, reset stays asserted until the clock edge that samples the HOLD_TICKS-th cycle with `tick` = 1. At that edge it is released (`rst_n_out` = 1).
- R3: While `supply_ok` is 0, the recovery count is cleared and held, whatever ticks arrive. Counting starts from zero only once the supply is good again.
- R4: A cause that lasts a single clock cycle still produces a reset of the full recovery period.
- R5: Reset stays asserted for as long as `mr_n` is held low, for any number of ticks. After `mr_n` returns high, the full recovery period follows.
- R6: After the synchronous reset `rst`, the outputs are asserted. They stay asserted until the supply is good and a full recovery period has then elapsed.
- R7: If a cause reappears while the recovery count is running, the count restarts from zero once the cause clears again.
- R8: The recovery count advances only in cycles where `tick` = 1. With no ticks, reset stays asserted indefinitely.
- R9: With the default output selection (both outputs driven), `rst_out` is always the complement of `rst_n_out`.
- R10: `recovering` is 1 exactly when no cause is active and reset is still held by the recovery count. It is 0 while a cause is active and 0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| tick | input | 1 | Timebase enable, one cycle wide per tick |
| supply_ok | input | 1 | Synchronised supply-good flag, 1 when the supply is above threshold |
| mr_n | input | 1 | Manual-reset request, active low, already debounced |
| rst_n_out | output | 1 | Reset output, active low |
| rst_out | output | 1 | Reset output, active high |
| recovering | output | 1 | High while the recovery count is running |

## Verification
The state in this block is a tick counter and a release flag. If the counter keeps a stale value, the release moves earlier or later by whole ticks. If the release flag is wrong, reset drops while a cause is still fresh, or never drops. The bench therefore samples the outputs one tick before release and again at the release tick. A miscount shows within one recovery period of a cause clearing. A missed clear on a cause that reappears shows as an early release in the restart and single-cycle-glitch scenarios.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

    typedef enum logic [1:0] {
        OUT_BOTH      = 2'd0,
        OUT_LOW_ONLY  = 2'd1,
        OUT_HIGH_ONLY = 2'd2
    } out_sel_e;

    typedef enum logic [1:0] {
        PH_HELD    = 2'd0,
        PH_RECOVER = 2'd1,
        PH_RUN     = 2'd2
    } phase_e;

    typedef struct packed {
        logic sup_bad;
        logic manual;
    } cause_t;

    function automatic logic any_cause(cause_t c);
        return c.sup_bad | c.manual;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sup_cause_merge.sv
module sup_cause_merge
    import sup_rst_pkg::*;
(
    input  logic   supply_ok,
    input  logic   mr_n,
    output cause_t causes,
    output logic   active
);
    always_comb begin
        causes.sup_bad = ~supply_ok;
        causes.manual  = ~mr_n;
        active         = any_cause(causes);
    end
endmodule

// File: rtl/sup_recovery_timer.sv
module sup_recovery_timer
    import sup_rst_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = cnt_width(HOLD_TICKS);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q && tick) begin
            if (cnt_q == LAST) begin
                cnt_q  <= '0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = done_q;
endmodule

// File: rtl/sup_rst_drive.sv
module sup_rst_drive
    import sup_rst_pkg::*;
#(
    parameter out_sel_e OUT_SEL = OUT_BOTH
) (
    input  logic hold,
    output logic rst_n_o,
    output logic rst_o
);
    generate
        if (OUT_SEL == OUT_LOW_ONLY) begin : g_low
            assign rst_n_o = ~hold;
            assign rst_o   = 1'b0;
        end else if (OUT_SEL == OUT_HIGH_ONLY) begin : g_high
            assign rst_n_o = 1'b1;
            assign rst_o   = hold;
        end else begin : g_both
            assign rst_n_o = ~hold;
            assign rst_o   = hold;
        end
    endgenerate
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen
    import sup_rst_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 200,
    parameter out_sel_e    OUT_SEL    = OUT_BOTH
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic supply_ok,
    input  logic mr_n,
    output logic rst_n_out,
    output logic rst_out,
    output logic recovering
);
    cause_t causes;
    logic   cause_active;
    logic   timer_done;
    phase_e phase;

    sup_cause_merge u_merge (
        .supply_ok (supply_ok),
        .mr_n      (mr_n),
        .causes    (causes),
        .active    (cause_active)
    );

    sup_recovery_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (cause_active),
        .tick  (tick),
        .done  (timer_done)
    );

    always_comb begin
        if (cause_active)     phase = PH_HELD;
        else if (!timer_done) phase = PH_RECOVER;
        else                  phase = PH_RUN;
    end

    sup_rst_drive #(.OUT_SEL(OUT_SEL)) u_drive (
        .hold    (phase != PH_RUN),
        .rst_n_o (rst_n_out),
        .rst_o   (rst_out)
    );

    assign recovering = (phase == PH_RECOVER);
endmodule

// File: rtl/sup_rst_gen_chk.sv
module sup_rst_gen_chk
    import sup_rst_pkg::*;
#(
    parameter out_sel_e OUT_SEL = OUT_BOTH
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic supply_ok,
    input logic mr_n,
    input logic rst_n_out,
    input logic rst_out,
    input logic recovering
);
    logic held;
    assign held = (OUT_SEL == OUT_HIGH_ONLY) ? rst_out : ~rst_n_out;

    a_r1_cause_asserts: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok || !mr_n) |-> held);

    a_r4_min_width: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok || !mr_n) |=> held);

    a_r8_no_release_without_tick: assert property (@(posedge clk) disable iff (rst)
        (held && !tick) |=> held);

    a_r10_recover_only_when_held: assert property (@(posedge clk) disable iff (rst)
        recovering |-> (held && supply_ok && mr_n));

    generate
        if (OUT_SEL == OUT_BOTH) begin : g_cmp
            a_r9_complement: assert property (@(posedge clk) disable iff (rst)
                rst_out == !rst_n_out);
        end
    endgenerate
endmodule

bind sup_rst_gen sup_rst_gen_chk #(.OUT_SEL(OUT_SEL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .supply_ok  (supply_ok),
    .mr_n       (mr_n),
    .rst_n_out  (rst_n_out),
    .rst_out    (rst_out),
    .recovering (recovering)
);

// File: tb/sup_rst_gen_tb.sv
module sup_rst_gen_tb;
    localparam int unsigned H = 5;

    logic clk = 1'b0;
    logic rst, tick, supply_ok, mr_n;
    logic rst_n_out, rst_out, recovering;
    int   checks = 0;
    int   fails  = 0;

    always #10 clk = ~clk;

    sup_rst_gen #(.HOLD_TICKS(H)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok), .mr_n(mr_n),
        .rst_n_out(rst_n_out), .rst_out(rst_out), .recovering(recovering)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // checks both polarities; the high output must mirror the low one (R9)
    task automatic chk_rst(input logic exp_held, input logic exp_rec, input string tag);
        chk(rst_n_out, ~exp_held, tag);
        chk(rst_out, exp_held, {tag, " R9 complement"});
        chk(recovering, exp_rec, {tag, " R10 status"});
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic expect_release(input string tag);
        do_ticks(H - 1);
        chk_rst(1'b1, 1'b1, {tag, " one tick before release"});
        do_ticks(1);
        chk_rst(1'b0, 1'b0, {tag, " released"});
    endtask

    task automatic t_powerup;
        do_ticks(8);
        chk_rst(1'b1, 1'b0, "R3 supply bad holds count");
        @(negedge clk) supply_ok = 1'b1;
        expect_release("R6 power-up R2");
    endtask

    task automatic t_glitch;
        @(negedge clk) supply_ok = 1'b0;
        #1 chk_rst(1'b1, 1'b0, "R1 same-cycle assert on supply");
        @(negedge clk) supply_ok = 1'b1;
        expect_release("R4 one-cycle cause");
    endtask

    task automatic t_manual;
        @(negedge clk) mr_n = 1'b0;
        #1 chk_rst(1'b1, 1'b0, "R1 same-cycle assert on manual");
        do_ticks(12);
        chk_rst(1'b1, 1'b0, "R5 manual held low");
        @(negedge clk) mr_n = 1'b1;
        expect_release("R5 after manual release");
    endtask

    task automatic t_restart;
        @(negedge clk) mr_n = 1'b0;
        @(negedge clk) mr_n = 1'b1;
        do_ticks(3);
        chk_rst(1'b1, 1'b1, "R7 mid recovery");
        @(negedge clk) mr_n = 1'b0;
        @(negedge clk) mr_n = 1'b1;
        expect_release("R7 restart from zero");
        @(negedge clk) mr_n = 1'b0;
        @(negedge clk) mr_n = 1'b1;
        do_ticks(2);
        @(negedge clk) supply_ok = 1'b0;
        do_ticks(2);
        @(negedge clk) supply_ok = 1'b1;
        expect_release("R3 supply drop clears count");
    endtask

    task automatic t_no_tick;
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        repeat (60) @(negedge clk);
        chk_rst(1'b1, 1'b1, "R8 no ticks no release");
        expect_release("R8 ticks resume");
    endtask

    initial begin
        #4_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; supply_ok = 1'b0; mr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_rst(1'b1, 1'b0, "R6 reset state");
        supply_ok = 1'b1;
        @(negedge clk);
        chk_rst(1'b1, 1'b1, "R6 in reset with supply good");
        supply_ok = 1'b0;
        rst = 1'b0;
        t_powerup();
        t_glitch();
        t_manual();
        t_restart();
        t_no_tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule